// File: doc/BRIEF.md
# Keyed-Hash Command and Error Controller

This block sits in front of a keyed-hash engine. Software drives it through simple write ports: a 4-bit configuration word, eight 32-bit key words, start and process command pulses, and a valid/ready message port. The controller moves through three states. It is idle until a legal start arrives, active while message words stream in, and processing once the end of the message has been signalled. It locks configuration and key while it is not idle. It catches illegal software sequences and reports each one as a 3-bit code with a sticky error interrupt. It applies optional byte reversal to message words on the way in and to digest words on the way out.

The compression core is not part of this block. A stand-in engine takes the place of the real core. It pops one FIFO word every `PACE` cycles while the controller is not idle. Once the FIFO has drained after the process command, it waits `DONE_LAT` cycles and then finishes. At that point it latches an arithmetic digest so that data integrity, key use and byte order can be observed at the ports.

Top module: `khash_ctl`

## Requirements
- R1: The configuration word has four fields. Bit 0 enables the engine, bit 1 selects keyed mode, bit 2 reverses the bytes of message words and bit 3 reverses the bytes of digest words. A write while idle appears on `cfg_q` one cycle later.
- R2: With bit 2 set, each accepted message word is stored with its byte order reversed: byte 0 swaps with byte 3, and byte 1 swaps with byte 2.
- R3: With bit 3 set, `dig_rdata` returns the selected digest word with its byte order reversed.
- R4: `state_o` encodes idle as 0, active as 1 and processing as 2. A configuration write while not idle is discarded.
- R5: A key write while not idle is discarded and raises error code 3.
- R6: A message beat (valid and ready) while the engine is disabled raises code 1. The word is not stored.
- R7: A start while the engine is disabled raises code 2 and leaves the state unchanged. A start while not idle raises code 4 and leaves the state unchanged.
- R8: A message beat while processing raises code 5. The word is not stored.
- R9: Every error sets `intr_err` and loads `err_code`, which holds its value until the next error. When several errors occur in one cycle, the largest code wins. Writing 1 to clear bit 2 clears `intr_err`.
- R10: A legal start moves the state from idle to active. A process command moves it from active to processing. Completion sets `intr_done` and returns the state to idle. Writing 1 to clear bit 0 clears `intr_done`.
- R11: While the FIFO is full, `msg_ready` is low and `fifo_full` is high. Stalled words are delayed, never lost. `intr_fifo_full` (clear bit 1) is sticky.
- R12: Digest word i is rotl(X, 4i) + N + (keyed ? key[i] : 0), latched at completion. X is the XOR of the stored words and N is their count since start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration value |
| key_we | input | 1 | Key write strobe |
| key_idx | input | 3 | Key word index |
| key_wdata | input | 32 | Key word value |
| cmd_start | input | 1 | Start command pulse |
| cmd_process | input | 1 | End-of-message command pulse |
| msg_valid | input | 1 | Message word valid |
| msg_data | input | 32 | Message word |
| msg_ready | output | 1 | Message port can accept |
| intr_clr | input | 3 | Write-1-to-clear: bit0 done, bit1 FIFO full, bit2 error |
| dig_idx | input | 3 | Digest word select |
| dig_rdata | output | 32 | Selected digest word |
| cfg_q | output | 4 | Current configuration |
| state_o | output | 2 | Controller state |
| fifo_full | output | 1 | FIFO full status |
| intr_done | output | 1 | Done interrupt state |
| intr_fifo_full | output | 1 | FIFO-full interrupt state |
| intr_err | output | 1 | Error interrupt state |
| err_code | output | 3 | Most recent error code |

## Verification
The checker covers five rules on every cycle. The configuration changes only out of idle. A start while disabled never moves the state. Processing persists until completion. Completion lands in idle with the done bit raised. Each error event is followed by the error bit and the chosen code. Digest arithmetic, byte reversal in both directions, key discard, word rejection and back-pressure that loses no word can only be shown by the bench. It sweeps all keyed and swap combinations over several message lengths and compares the digests it computes itself.

// File: rtl/khash_pkg.sv
package khash_pkg;
  localparam int NWORDS = 8;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACTIVE = 2'd1, ST_PROC = 2'd2} kstate_t;

  localparam logic [2:0] E_NONE       = 3'd0;
  localparam logic [2:0] E_MSG_OFF    = 3'd1;
  localparam logic [2:0] E_START_OFF  = 3'd2;
  localparam logic [2:0] E_KEY_BUSY   = 3'd3;
  localparam logic [2:0] E_START_BUSY = 3'd4;
  localparam logic [2:0] E_MSG_LATE   = 3'd5;

  function automatic logic [31:0] bswap32(input logic [31:0] x);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = x[8*(3-b) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] rotl32(input logic [31:0] x, input int s);
    logic [63:0] d;
    d = {x, x} << s;
    return d[63:32];
  endfunction

  function automatic logic [31:0] digest_word(input logic [31:0] acc, input logic [15:0] cnt,
                                              input logic [31:0] key, input logic keyed,
                                              input int idx);
    return rotl32(acc, 4 * idx) + {16'd0, cnt} + (keyed ? key : 32'd0);
  endfunction
endpackage

// File: rtl/khash_msg_fifo.sv
module khash_msg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= nxt(wp);
      if (pop && !empty) rp <= nxt(rp);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/khash_engine_stub.sv
module khash_engine_stub #(
  parameter int PACE     = 4,
  parameter int DONE_LAT = 8,
  parameter int CNTW     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            proc,
  input  logic            clear,
  input  logic            empty,
  input  logic [31:0]     rdata,
  output logic            pop,
  output logic [31:0]     acc,
  output logic [CNTW-1:0] cnt,
  output logic            done
);
  localparam int PW = $clog2(PACE + 1);
  localparam int LW = $clog2(DONE_LAT + 1);

  logic [PW-1:0] pace_q;
  logic [LW-1:0] lat_q;

  assign pop  = run && (pace_q == PW'(PACE - 1)) && !empty;
  assign done = proc && empty && (lat_q == LW'(DONE_LAT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pace_q <= '0;
      lat_q  <= '0;
      acc    <= '0;
      cnt    <= '0;
    end else begin
      if (!run || pace_q == PW'(PACE - 1)) pace_q <= '0;
      else                                 pace_q <= pace_q + 1'b1;

      if (!proc || !empty)                  lat_q <= '0;
      else if (lat_q != LW'(DONE_LAT - 1))  lat_q <= lat_q + 1'b1;

      if (clear) begin
        acc <= '0;
        cnt <= '0;
      end else if (pop) begin
        acc <= acc ^ rdata;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/khash_ctl.sv
module khash_ctl
  import khash_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int PACE     = 4,
  parameter int DONE_LAT = 8,
  parameter int CNTW     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_wdata,
  input  logic        key_we,
  input  logic [2:0]  key_idx,
  input  logic [31:0] key_wdata,
  input  logic        cmd_start,
  input  logic        cmd_process,
  input  logic        msg_valid,
  input  logic [31:0] msg_data,
  output logic        msg_ready,
  input  logic [2:0]  intr_clr,
  input  logic [2:0]  dig_idx,
  output logic [31:0] dig_rdata,
  output logic [3:0]  cfg_q,
  output logic [1:0]  state_o,
  output logic        fifo_full,
  output logic        intr_done,
  output logic        intr_fifo_full,
  output logic        intr_err,
  output logic [2:0]  err_code
);
  kstate_t         state_q;
  logic [31:0]     key_q [NWORDS];
  logic [31:0]     dig_q [NWORDS];
  logic            fifo_empty, pop, push;
  logic [31:0]     fifo_rdata, acc;
  logic [CNTW-1:0] cnt;

  // named events for the checker
  logic       beat, idle, en;
  logic       e_msg_off, e_start_off, e_key_busy, e_start_busy, e_msg_late;
  logic       err_evt, done_evt, start_ok;
  logic [2:0] err_nxt_code;

  assign idle      = (state_q == ST_IDLE);
  assign en        = cfg_q[0];
  assign msg_ready = !fifo_full;
  assign beat      = msg_valid && msg_ready;

  assign e_msg_off    = beat && !en;
  assign e_msg_late   = beat && en && (state_q == ST_PROC);
  assign e_start_off  = cmd_start && !en;
  assign e_start_busy = cmd_start && en && !idle;
  assign e_key_busy   = key_we && !idle;
  assign err_evt      = e_msg_off | e_msg_late | e_start_off | e_start_busy | e_key_busy;
  assign start_ok     = cmd_start && en && idle;
  assign push         = beat && en && (state_q != ST_PROC);

  always_comb begin
    if (e_msg_late)        err_nxt_code = E_MSG_LATE;
    else if (e_start_busy) err_nxt_code = E_START_BUSY;
    else if (e_key_busy)   err_nxt_code = E_KEY_BUSY;
    else if (e_start_off)  err_nxt_code = E_START_OFF;
    else if (e_msg_off)    err_nxt_code = E_MSG_OFF;
    else                   err_nxt_code = E_NONE;
  end

  khash_msg_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push),
    .wdata(cfg_q[2] ? bswap32(msg_data) : msg_data),
    .pop(pop), .rdata(fifo_rdata), .full(fifo_full), .empty(fifo_empty)
  );

  khash_engine_stub #(.PACE(PACE), .DONE_LAT(DONE_LAT), .CNTW(CNTW)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(!idle), .proc(state_q == ST_PROC),
    .clear(start_ok), .empty(fifo_empty), .rdata(fifo_rdata),
    .pop(pop), .acc(acc), .cnt(cnt), .done(done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      cfg_q          <= '0;
      err_code       <= E_NONE;
      intr_err       <= 1'b0;
      intr_done      <= 1'b0;
      intr_fifo_full <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:   if (start_ok)    state_q <= ST_ACTIVE;
        ST_ACTIVE: if (cmd_process) state_q <= ST_PROC;
        ST_PROC:   if (done_evt)    state_q <= ST_IDLE;
        default:                    state_q <= ST_IDLE;
      endcase
      if (cfg_we && idle) cfg_q <= cfg_wdata;
      if (err_evt) err_code <= err_nxt_code;
      intr_err       <= err_evt   | (intr_err       & ~intr_clr[2]);
      intr_done      <= done_evt  | (intr_done      & ~intr_clr[0]);
      intr_fifo_full <= fifo_full | (intr_fifo_full & ~intr_clr[1]);
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_q[i] <= '0;
        dig_q[i] <= '0;
      end else begin
        if (key_we && idle && key_idx == 3'(i)) key_q[i] <= key_wdata;
        if (done_evt) dig_q[i] <= digest_word(acc, 16'(cnt), key_q[i], cfg_q[1], i);
      end
    end
  end

  assign dig_rdata = cfg_q[3] ? bswap32(dig_q[dig_idx]) : dig_q[dig_idx];
  assign state_o   = state_q;
endmodule

module khash_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic [3:0] cfg_q,
  input logic [1:0] state_o,
  input logic       err_evt,
  input logic [2:0] err_nxt_code,
  input logic       done_evt,
  input logic       intr_err,
  input logic       intr_done,
  input logic [2:0] err_code
);
  a_r4_cfg_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> ($past(state_o) == 2'd0));

  a_r7_off_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cfg_q[0]) |=> (state_o == $past(state_o)));

  a_r9_err_latched: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (intr_err && err_code == $past(err_nxt_code)));

  a_r10_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (state_o == 2'd0 && intr_done));

  a_r10_proc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !done_evt) |=> (state_o == 2'd2));
endmodule

bind khash_ctl khash_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cfg_q(cfg_q), .state_o(state_o),
  .err_evt(err_evt), .err_nxt_code(err_nxt_code), .done_evt(done_evt),
  .intr_err(intr_err), .intr_done(intr_done), .err_code(err_code)
);

// File: tb/sim_khash_ctl.sv
module sim_khash_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, key_we = 0, cmd_start = 0, cmd_process = 0, msg_valid = 0;
  logic [3:0]  cfg_wdata = 0;
  logic [2:0]  key_idx = 0, intr_clr = 0, dig_idx = 0;
  logic [31:0] key_wdata = 0, msg_data = 0;
  logic        msg_ready, fifo_full, intr_done, intr_fifo_full, intr_err;
  logic [31:0] dig_rdata;
  logic [3:0]  cfg_q;
  logic [1:0]  state_o;
  logic [2:0]  err_code;

  int nchk = 0, nerr = 0, stalls = 0;
  logic [31:0] bkey [8];
  logic [31:0] xacc;
  int          xcnt;
  bit          fin = 0;

  always #2 clk = ~clk;

  khash_ctl u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] expect_word(input int i);
    logic [31:0] r;
    int s = 4 * i;
    r = (xacc << s) | (xacc >> (32 - s));
    r = r + 32'(xcnt) + (cfg_q[1] ? bkey[i] : 32'd0);
    return cfg_q[3] ? rev(r) : r;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
  endtask

  task automatic wr_key(input int i, input logic [31:0] v);
    key_we = 1; key_idx = 3'(i); key_wdata = v; tick(); key_we = 0;
  endtask

  task automatic pulse_start(); cmd_start = 1; tick(); cmd_start = 0; endtask
  task automatic pulse_proc();  cmd_process = 1; tick(); cmd_process = 0; endtask
  task automatic clr(input logic [2:0] m); intr_clr = m; tick(); intr_clr = 0; endtask

  // push one word, waiting out back-pressure; tracks expected store
  task automatic push(input logic [31:0] w, input bit stored);
    bit r;
    msg_valid = 1; msg_data = w;
    forever begin
      r = msg_ready;
      tick();
      if (r) break;
      stalls++;
    end
    msg_valid = 0;
    if (stored) begin
      xacc ^= (cfg_q[2] ? rev(w) : w);
      xcnt++;
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!intr_done && n < 500) begin tick(); n++; end
    chk(intr_done && state_o == 2'd0, {tag, " R10 done/idle"}, {30'd0, state_o}, 32'd0);
    clr(3'b001);
    chk(!intr_done, "R10 done cleared", {31'd0, intr_done}, 32'd0);
  endtask

  task automatic check_digest(input string tag);
    for (int i = 0; i < 8; i++) begin
      dig_idx = 3'(i);
      #1;
      chk(dig_rdata == expect_word(i), tag, dig_rdata, expect_word(i));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!fin) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) bkey[i] = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(state_o == 0 && cfg_q == 0 && err_code == 0 && !intr_err && !intr_done && msg_ready,
        "reset", {26'd0, state_o, cfg_q}, 32'd0);

    // R6: message while disabled is rejected and not stored
    push(32'h1111_2222, 0);
    tick();
    chk(err_code == 3'd1 && intr_err, "R6 msg while off", {29'd0, err_code}, 32'd1);
    clr(3'b100);
    chk(!intr_err, "R9 err cleared", {31'd0, intr_err}, 32'd0);
    // R7: start while disabled
    pulse_start();
    chk(err_code == 3'd2 && state_o == 0, "R7 start while off", {27'd0, err_code, state_o}, {27'd0, 3'd2, 2'd0});

    // sweep: all keyed/swap combinations, lengths 1..6
    for (int c = 0; c < 8; c++) begin
      wr_cfg({c[2], c[1], c[0], 1'b1});
      chk(cfg_q == {c[2], c[1], c[0], 1'b1}, "R1 cfg write", {28'd0, cfg_q}, {28'd0, c[2], c[1], c[0], 1'b1});
      for (int k = 0; k < 8; k++) begin
        bkey[k] = 32'h9e37_79b9 * (c * 8 + k + 1);
        wr_key(k, bkey[k]);
      end
      for (int len = 1; len <= 6; len++) begin
        xacc = 0; xcnt = 0;
        pulse_start();
        chk(state_o == 2'd1, "R10 start to active", {30'd0, state_o}, 32'd1);
        for (int w = 0; w < len; w++) push(32'h0102_0304 * (w + 1) ^ 32'(c << 20) ^ 32'(len), 1);
        pulse_proc();
        wait_done("sweep");
        check_digest("R12/R2/R3 digest");
      end
    end
    chk(stalls > 0 && intr_fifo_full, "R11 back-pressure seen", 32'(stalls), 32'd1);
    clr(3'b010);
    chk(!intr_fifo_full, "R11 full intr cleared", {31'd0, intr_fifo_full}, 32'd0);

    // error sequence, keyed mode, no swaps
    wr_cfg(4'b0011);
    xacc = 0; xcnt = 0;
    pulse_start();
    pulse_start();
    chk(err_code == 3'd4 && state_o == 2'd1, "R7 start while busy", {29'd0, err_code}, 32'd4);
    wr_key(2, 32'hdead_beef);
    chk(err_code == 3'd3, "R5 key while busy", {29'd0, err_code}, 32'd3);
    wr_cfg(4'b1111);
    chk(cfg_q == 4'b0011, "R4 cfg locked", {28'd0, cfg_q}, 32'h3);
    cmd_start = 1; key_we = 1; key_idx = 0; key_wdata = 32'h5555_5555; tick();
    cmd_start = 0; key_we = 0;
    chk(err_code == 3'd4, "R9 highest code wins", {29'd0, err_code}, 32'd4);
    push(32'hcafe_f00d, 1);
    push(32'h0bad_c0de, 1);
    pulse_proc();
    chk(state_o == 2'd2, "R10 process", {30'd0, state_o}, 32'd2);
    push(32'h7777_7777, 0);
    tick();
    chk(err_code == 3'd5, "R8 msg after process", {29'd0, err_code}, 32'd5);
    wait_done("errseq");
    check_digest("R12/R5/R8 digest excludes rejects");
    clr(3'b100);
    wr_cfg(4'b0001);
    chk(cfg_q == 4'b0001 && err_code == 3'd5, "R4 cfg writable again, R9 code kept", {25'd0, err_code, cfg_q}, {25'd0, 3'd5, 4'd1});

    fin = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule